// File: doc/BRIEF.md
# Two-Stage Fetch/Execute Pipeline Controller

This block sequences instruction flow for a small processor core with separate program memory. Each cycle it presents a byte address to program memory and receives a 16-bit word in the same cycle. That word is latched into the execute slot, and it executes in the following cycle while the next word is being fetched. The controller keeps the program counter, decodes the instruction class of the word in the execute slot, and handles every change of flow itself: jumps, subroutine calls, returns, branches requested by the external datapath, and interrupts.

Long instructions occupy two program words. The controller presents the first word together with the word being fetched in the same cycle, so the whole instruction is visible on the execute outputs at once. The slot that would have held the second word is then a bubble. A change of flow discards the word already fetched, so the target executes two cycles after the redirecting instruction. Return addresses live in a hardware stack of configurable depth. Misuse of the stack raises a sticky error flag and leaves the stored contents alone.

Top module: `fe_pipe_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the fetch address is 0, the execute slot holds a no-operation (ex_valid low) and stk_err is low. The word at address 0 executes in the second cycle after release.
- R2: With no change of flow, the fetch address rises by 2 every cycle, and each fetched word executes (ex_addr equal to its address) in the next cycle.
- R3: The class comes from bits 15:12 of the word in the execute slot and appears on ex_kind: 0x0 is no-operation (kind 0), 0xA is return (4), 0xB is pointer load (6), 0xC is memory move (5), 0xD is jump (2), 0xE is call (3), 0xF is a second word (executes as kind 0), and any other value is an ordinary operation (1). For kinds 2, 3, 5 and 6, ex_ext carries the second word in the same cycle, and the next cycle is a bubble.
- R4: A jump or call targets the word address formed from bits 11:0 of the second word (upper part) and bits 7:0 of the first word (lower part). The fetch address becomes twice that value. The target executes two cycles after the jump or call.
- R5: A call pushes its own address plus 4. A return pops the most recent entry and redirects there, and the returned-to instruction executes two cycles after the return.
- R6: A second word (0xF) that reaches the execute slot by itself, for example as a jump target, executes as a no-operation and ex_valid stays low.
- R7: br_taken redirects to br_target with bit 0 cleared only when the execute slot holds an ordinary operation. The target then executes two cycles later. In any other cycle br_taken has no effect.
- R8: irq_req is not taken while the execute slot holds a two-word instruction, a jump, a call or a return. When it is taken, irq_ack pulses, the address being fetched is pushed, the fetched word is discarded and fetch resumes at IRQ_VEC.
- R9: A push when the stack holds STACK_DEPTH entries sets the sticky stk_err, stores nothing and leaves earlier entries intact. The call still jumps.
- R10: A return with an empty stack sets stk_err and redirects to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one instruction cycle per edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | PC_W | Byte address of the word being fetched |
| imem_data | input | IW | Program word at imem_addr, same cycle |
| ex_valid | output | 1 | Execute slot holds a real instruction |
| ex_kind | output | 3 | Instruction class of the execute slot |
| ex_word | output | IW | First word of the executing instruction |
| ex_ext | output | IW | Second word for two-word classes |
| ex_addr | output | PC_W | Byte address of the executing instruction |
| br_taken | input | 1 | Datapath requests a redirect for the current ordinary operation |
| br_target | input | PC_W | Byte address for that redirect |
| irq_req | input | 1 | Level interrupt request |
| irq_ack | output | 1 | Interrupt taken at the end of this cycle |
| stk_err | output | 1 | Sticky stack overflow or underflow flag |

## Verification
The assertions check, on every cycle, the properties that are local in time. These are the reset state, the plus-2 advance of the fetch address, the bubble after each two-word instruction and each redirect, the blocking of interrupts across two-word and redirecting instructions, the landing on the vector, and the stickiness of the error flag. Only the bench scenarios can show that targets are assembled correctly, that the stack returns entries in the right order after an overflow, that orphaned second words stay silent, and that the spacing between executed instructions is exactly two cycles after each kind of redirect. A scoreboard compares address, class, second word, cycle gap and error flag against hand-derived traces.

// File: rtl/fe_pipe_pkg.sv
// Shared instruction classes and opcode nibbles for the fetch/execute controller.
// Assumes the class is carried in the top four bits of a program word.
package fe_pipe_pkg;
    typedef enum logic [2:0] {
        K_NOP  = 3'd0,
        K_OP   = 3'd1,
        K_GOTO = 3'd2,
        K_CALL = 3'd3,
        K_RET  = 3'd4,
        K_MOVE = 3'd5,
        K_PTR  = 3'd6
    } ikind_e;

    localparam logic [3:0] OPC_NOP  = 4'h0;
    localparam logic [3:0] OPC_RET  = 4'hA;
    localparam logic [3:0] OPC_PTR  = 4'hB;
    localparam logic [3:0] OPC_MOVE = 4'hC;
    localparam logic [3:0] OPC_GOTO = 4'hD;
    localparam logic [3:0] OPC_CALL = 4'hE;
    localparam logic [3:0] OPC_CONT = 4'hF;
endpackage

// File: rtl/fe_pipe_decode.sv
// Classifies the word in the execute slot from its opcode nibble.
// Assumes a continuation nibble never starts an instruction, so it decodes as a no-op.
module fe_pipe_decode
    import fe_pipe_pkg::*;
(
    input  logic [3:0] opc,
    output ikind_e     kind,
    output logic       two_word
);
    // Map the opcode nibble to an instruction class.
    always_comb begin
        unique case (opc)
            OPC_NOP:  kind = K_NOP;
            OPC_CONT: kind = K_NOP;
            OPC_RET:  kind = K_RET;
            OPC_PTR:  kind = K_PTR;
            OPC_MOVE: kind = K_MOVE;
            OPC_GOTO: kind = K_GOTO;
            OPC_CALL: kind = K_CALL;
            default:  kind = K_OP;
        endcase
    end

    // Flag the classes whose operand spills into the following word.
    always_comb begin
        two_word = (kind == K_GOTO) || (kind == K_CALL) ||
                   (kind == K_MOVE) || (kind == K_PTR);
    end
endmodule

// File: rtl/fe_next_pc.sv
// Decides whether the executing instruction redirects fetch and where to.
// Assumes the second word of a jump/call is the word being fetched this cycle.
module fe_next_pc
    import fe_pipe_pkg::*;
#(
    parameter int PC_W = 21,
    parameter int LO_W = 8
) (
    input  ikind_e              kind,
    input  logic [LO_W-1:0]     first_lo,
    input  logic [PC_W-2-LO_W:0] second_hi,
    input  logic                br_taken,
    input  logic [PC_W-1:0]     br_target,
    input  logic [PC_W-1:0]     pop_data,
    output logic                redirect,
    output logic [PC_W-1:0]     target
);
    localparam logic [PC_W-1:0] ALIGN_MASK = ~PC_W'(1);

    logic [PC_W-1:0] jump_addr;

    // Build the byte address of a jump/call target from both words.
    always_comb begin
        jump_addr = {second_hi, first_lo, 1'b0};
    end

    // Select redirect source by class of the executing instruction.
    always_comb begin
        redirect = 1'b0;
        target   = jump_addr;
        unique case (kind)
            K_GOTO, K_CALL: redirect = 1'b1;
            K_RET: begin
                redirect = 1'b1;
                target   = pop_data;
            end
            K_OP: begin
                redirect = br_taken;
                target   = br_target & ALIGN_MASK;
            end
            default: redirect = 1'b0;
        endcase
    end
endmodule

// File: rtl/fe_ret_stack.sv
// Return-address stack with a depth counter and a sticky misuse flag.
// Assumes push and pop are never requested in the same cycle.
module fe_ret_stack #(
    parameter int PC_W  = 21,
    parameter int DEPTH = 31
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic [PC_W-1:0] push_data,
    output logic [PC_W-1:0] top_data,
    output logic            err
);
    localparam int SP_W = $clog2(DEPTH + 1);
    localparam logic [SP_W-1:0] SP_FULL = SP_W'(DEPTH);

    logic [SP_W-1:0] sp;
    logic [PC_W-1:0] ent [DEPTH];
    logic            full;
    logic            empty;

    assign full  = (sp == SP_FULL);
    assign empty = (sp == '0);

    // One storage register per level, written only when it is the free slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_level
        always_ff @(posedge clk) begin
            if (push && !full && (sp == SP_W'(g))) begin
                ent[g] <= push_data;
            end
        end
    end

    // Track depth and latch any overflow or underflow attempt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp  <= '0;
            err <= 1'b0;
        end else begin
            if (push && !full) begin
                sp <= sp + SP_W'(1);
            end else if (pop && !empty) begin
                sp <= sp - SP_W'(1);
            end
            if ((push && full) || (pop && empty)) begin
                err <= 1'b1;
            end
        end
    end

    // Present the newest entry, or address zero when empty.
    always_comb begin
        top_data = empty ? '0 : ent[sp - SP_W'(1)];
    end
endmodule

// File: rtl/fe_pipe_ctrl.sv
// Two-stage fetch/execute controller: owns the program counter, the execute
// slot, redirects, interrupt entry and the return stack.
// Assumes program memory answers combinationally within the same cycle.
module fe_pipe_ctrl
    import fe_pipe_pkg::*;
#(
    parameter int              PC_W        = 21,
    parameter int              IW          = 16,
    parameter int              STACK_DEPTH = 31,
    parameter logic [PC_W-1:0] IRQ_VEC     = 21'h000040
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PC_W-1:0] imem_addr,
    input  logic [IW-1:0]   imem_data,
    output logic            ex_valid,
    output logic [2:0]      ex_kind,
    output logic [IW-1:0]   ex_word,
    output logic [IW-1:0]   ex_ext,
    output logic [PC_W-1:0] ex_addr,
    input  logic            br_taken,
    input  logic [PC_W-1:0] br_target,
    input  logic            irq_req,
    output logic            irq_ack,
    output logic            stk_err
);
    localparam int LO_W = 8;
    localparam int HI_W = PC_W - 1 - LO_W;
    localparam logic [PC_W-1:0] STEP  = PC_W'(2);
    localparam logic [PC_W-1:0] SKIP2 = PC_W'(4);

    logic [PC_W-1:0] pc;
    logic [IW-1:0]   ir;
    logic [PC_W-1:0] ir_pc;
    ikind_e          kind;
    logic            two_word;
    logic            redirect;
    logic [PC_W-1:0] target;
    logic [PC_W-1:0] pop_data;
    logic            irq_take;
    logic            push;
    logic            pop;
    logic [PC_W-1:0] push_data;
    logic [PC_W-1:0] pc_nxt;
    logic [IW-1:0]   ir_nxt;

    fe_pipe_decode u_dec (
        .opc      (ir[IW-1 -: 4]),
        .kind     (kind),
        .two_word (two_word)
    );

    fe_next_pc #(.PC_W(PC_W), .LO_W(LO_W)) u_npc (
        .kind      (kind),
        .first_lo  (ir[LO_W-1:0]),
        .second_hi (imem_data[HI_W-1:0]),
        .br_taken  (br_taken),
        .br_target (br_target),
        .pop_data  (pop_data),
        .redirect  (redirect),
        .target    (target)
    );

    fe_ret_stack #(.PC_W(PC_W), .DEPTH(STACK_DEPTH)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_data (push_data),
        .top_data  (pop_data),
        .err       (stk_err)
    );

    // Accept an interrupt only at a clean boundary with no redirect pending.
    always_comb begin
        irq_take = irq_req && !two_word && !redirect;
    end

    // Stack traffic: calls and interrupts push, returns pop.
    always_comb begin
        push      = (kind == K_CALL) || irq_take;
        pop       = (kind == K_RET);
        push_data = irq_take ? pc : (ir_pc + SKIP2);
    end

    // Next fetch address and next execute-slot contents.
    always_comb begin
        if (irq_take) begin
            pc_nxt = IRQ_VEC;
        end else if (redirect) begin
            pc_nxt = target;
        end else begin
            pc_nxt = pc + STEP;
        end
        ir_nxt = (irq_take || redirect || two_word) ? '0 : imem_data;
    end

    // Pipeline registers: program counter and execute slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc    <= '0;
            ir    <= '0;
            ir_pc <= '0;
        end else begin
            pc    <= pc_nxt;
            ir    <= ir_nxt;
            ir_pc <= pc;
        end
    end

    // Drive the decoded execute-stage view and handshakes.
    always_comb begin
        imem_addr = pc;
        ex_valid  = (kind != K_NOP);
        ex_kind   = kind;
        ex_word   = ir;
        ex_ext    = imem_data;
        ex_addr   = ir_pc;
        irq_ack   = irq_take;
    end
endmodule

// File: rtl/fe_pipe_ctrl_chk.sv
// Cycle-level properties of the fetch/execute controller, bound to the top.
// Assumes the class encoding from the shared package.
module fe_pipe_ctrl_chk
    import fe_pipe_pkg::*;
#(
    parameter int              PC_W    = 21,
    parameter logic [PC_W-1:0] IRQ_VEC = 21'h000040
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] imem_addr,
    input logic            ex_valid,
    input logic [2:0]      ex_kind,
    input logic            br_taken,
    input logic            irq_ack,
    input logic            stk_err
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!ex_valid && imem_addr == '0 && !stk_err));

    a_r2_seq_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_kind == K_OP && !br_taken && !irq_ack) |=>
        (imem_addr == $past(imem_addr) + PC_W'(2)));

    a_r3_two_word_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_kind == K_MOVE || ex_kind == K_PTR) |=> !ex_valid);

    a_r4_redirect_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_kind == K_GOTO || ex_kind == K_CALL || ex_kind == K_RET) |=> !ex_valid);

    a_r7_br_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_valid && br_taken && !irq_ack) |=>
        (imem_addr == $past(imem_addr) + PC_W'(2)));

    a_r8_no_split: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_kind == K_GOTO || ex_kind == K_CALL || ex_kind == K_RET ||
         ex_kind == K_MOVE || ex_kind == K_PTR) |-> !irq_ack);

    a_r8_vector: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (imem_addr == IRQ_VEC && !ex_valid));

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stk_err |=> stk_err);
endmodule

bind fe_pipe_ctrl fe_pipe_ctrl_chk #(.PC_W(PC_W), .IRQ_VEC(IRQ_VEC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_addr (imem_addr),
    .ex_valid  (ex_valid),
    .ex_kind   (ex_kind),
    .br_taken  (br_taken),
    .irq_ack   (irq_ack),
    .stk_err   (stk_err)
);

// File: tb/fe_pipe_ctrl_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: scenarios queue the expected execution trace, a monitor
// compares every executed instruction against it at the falling edge.
module fe_pipe_ctrl_tb;
    localparam int PC_W = 21;
    localparam int IW   = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] imem_addr;
    logic [IW-1:0]   imem_data;
    logic            ex_valid;
    logic [2:0]      ex_kind;
    logic [IW-1:0]   ex_word;
    logic [IW-1:0]   ex_ext;
    logic [PC_W-1:0] ex_addr;
    logic            br_taken = 1'b0;
    logic [PC_W-1:0] br_target = 21'h10;
    logic            irq_req = 1'b0;
    logic            irq_ack;
    logic            stk_err;

    logic [15:0] mem [0:255];
    assign imem_data = mem[imem_addr[8:1]];

    always #2 clk = ~clk;

    fe_pipe_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
        .ex_valid(ex_valid), .ex_kind(ex_kind), .ex_word(ex_word), .ex_ext(ex_ext),
        .ex_addr(ex_addr), .br_taken(br_taken), .br_target(br_target),
        .irq_req(irq_req), .irq_ack(irq_ack), .stk_err(stk_err)
    );

    typedef struct {
        int    addr;
        int    kind;
        int    ext;
        int    gap;
        int    err;
        string tag;
    } exp_t;

    exp_t expq[$];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last = 0;
    int br_mode = 0;
    int br_hold = 0;
    int irq_mode = 0;
    bit irq_seen = 0;
    bit irq_done = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic expect_ex(input int addr, input int kind, input int ext,
                             input int gap, input int err, input string tag);
        exp_t e;
        e.addr = addr; e.kind = kind; e.ext = ext; e.gap = gap; e.err = err; e.tag = tag;
        expq.push_back(e);
    endtask

    // Count active edges since reset release.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Monitor: pop and compare each executed instruction.
    always @(negedge clk) begin
        if (!rst_n) begin
            last = 0;
        end else if (ex_valid && expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            chk(int'(ex_addr) == e.addr, e.tag, "ex_addr", int'(ex_addr), e.addr);
            chk(int'(ex_kind) == e.kind, e.tag, "ex_kind", int'(ex_kind), e.kind);
            if (e.ext >= 0) chk(int'(ex_ext) == e.ext, e.tag, "ex_ext", int'(ex_ext), e.ext);
            if (e.gap > 0)  chk(cyc - last == e.gap, e.tag, "cycle gap", cyc - last, e.gap);
            if (e.err >= 0) chk(int'(stk_err) == e.err, e.tag, "stk_err", int'(stk_err), e.err);
            last = cyc;
        end else if (ex_valid) begin
            last = cyc;
        end
    end

    // Branch driver: request a redirect while 0x2 executes and one cycle after.
    always @(negedge clk) begin
        if (br_mode != 0 && ex_valid && int'(ex_addr) == 2) br_hold = 2;
        if (br_hold > 0) begin
            br_taken = 1'b1;
            br_hold--;
        end else begin
            br_taken = 1'b0;
        end
    end

    // Interrupt driver: raise during the move, expect the ack one cycle later.
    always @(negedge clk) begin
        if (irq_mode != 0) begin
            if (irq_seen && irq_req) begin
                irq_req  = 1'b0;
                irq_done = 1'b1;
            end else if (irq_req) begin
                chk(irq_ack == 1'b1, "R8", "irq_ack in bubble after move", int'(irq_ack), 1);
                irq_seen = 1'b1;
            end else if (!irq_done && ex_valid && int'(ex_kind) == 5 && int'(ex_addr) == 8) begin
                irq_req = 1'b1;
            end
        end
    end

    task automatic enter_reset();
        @(negedge clk);
        rst_n = 1'b0;
        br_mode = 0;
        irq_mode = 0;
        expq.delete();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        repeat (2) @(negedge clk);
    endtask

    task automatic leave_reset(input string tag);
        rst_n = 1'b1;
        chk(ex_valid == 1'b0, tag, "R1 ex_valid after reset", int'(ex_valid), 0);
        chk(imem_addr == '0, tag, "R1 fetch address after reset", int'(imem_addr), 0);
        chk(stk_err == 1'b0, tag, "R1 stk_err after reset", int'(stk_err), 0);
    endtask

    task automatic drain(input int maxc, input string tag);
        for (int i = 0; i < maxc && expq.size() > 0; i++) @(negedge clk);
        @(negedge clk);
        chk(expq.size() == 0, tag, "pending expected items", expq.size(), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Scenario A: straight line, two-word classes, call/return, jumps, orphan word.
        enter_reset();
        mem[0]  = 16'h1001;
        mem[1]  = 16'hC123; mem[2]  = 16'hF456;
        mem[3]  = 16'hB2A5; mem[4]  = 16'hF0FF;
        mem[5]  = 16'hE010; mem[6]  = 16'hF000;
        mem[7]  = 16'h1007;
        mem[8]  = 16'hD020; mem[9]  = 16'hF000;
        mem[10] = 16'h100A;
        mem[16] = 16'h1010; mem[17] = 16'hA000;
        mem[32] = 16'hD022; mem[33] = 16'hF000;
        mem[34] = 16'hF123;
        mem[35] = 16'h1023;
        mem[36] = 16'hD024; mem[37] = 16'hF000;
        expect_ex(16'h00, 1, -1,     1, -1, "R1");
        expect_ex(16'h02, 5, 'hF456, 1, -1, "R3");
        expect_ex(16'h06, 6, 'hF0FF, 2, -1, "R3");
        expect_ex(16'h0A, 3, 'hF000, 2, -1, "R4");
        expect_ex(16'h20, 1, -1,     2, -1, "R4");
        expect_ex(16'h22, 4, -1,     1, -1, "R5");
        expect_ex(16'h0E, 1, -1,     2, -1, "R5");
        expect_ex(16'h10, 2, 'hF000, 1, -1, "R2");
        expect_ex(16'h40, 2, 'hF000, 2, -1, "R4");
        expect_ex(16'h46, 1, -1,     3,  0, "R6");
        leave_reset("R1");
        drain(100, "R2");

        // Scenario B: nested calls beyond the stack depth, then unwinding.
        enter_reset();
        for (int k = 0; k < 32; k++) begin
            mem[3*k]   = 16'hE000 | 16'(3*(k+1));
            mem[3*k+1] = 16'hF000;
            mem[3*k+2] = 16'hA000;
        end
        mem[96] = 16'hA000;
        for (int k = 0; k < 32; k++) begin
            expect_ex(6*k, 3, 'hF000, (k == 0) ? 1 : 2, (k == 31) ? 0 : -1, "R5");
        end
        expect_ex(192, 4, -1, 2, 1, "R9");
        for (int k = 30; k >= 0; k--) begin
            expect_ex(6*k + 4, 4, -1, 2, -1, "R9");
        end
        leave_reset("R1");
        drain(400, "R9");
        chk(stk_err == 1'b1, "R9", "stk_err after overflow", int'(stk_err), 1);

        // Scenario C: return with an empty stack.
        enter_reset();
        mem[0] = 16'hA000;
        expect_ex(0, 4, -1, 1, 0, "R10");
        expect_ex(0, 4, -1, 2, 1, "R10");
        leave_reset("R1");
        drain(50, "R10");

        // Scenario D: external branch, honoured once, ignored on the flush slot.
        enter_reset();
        mem[0] = 16'h1000; mem[1] = 16'h1001; mem[2] = 16'h1002;
        mem[8] = 16'h1008; mem[9] = 16'h1009;
        mem[10] = 16'hD00A; mem[11] = 16'hF000;
        expect_ex(16'h00, 1, -1, 1, -1, "R2");
        expect_ex(16'h02, 1, -1, 1, -1, "R7");
        expect_ex(16'h10, 1, -1, 2, -1, "R7");
        expect_ex(16'h12, 1, -1, 1, -1, "R7");
        br_mode = 1;
        leave_reset("R1");
        drain(50, "R7");

        // Scenario E: interrupt raised during a two-word instruction.
        enter_reset();
        irq_seen = 0;
        irq_done = 0;
        mem[0] = 16'h1000; mem[1] = 16'h1001; mem[2] = 16'h1002; mem[3] = 16'h1003;
        mem[4] = 16'hC000; mem[5] = 16'hF111;
        mem[6] = 16'h1006; mem[7] = 16'h1007;
        mem[8] = 16'hD008; mem[9] = 16'hF000;
        mem[32] = 16'h1020; mem[33] = 16'hA000;
        expect_ex(16'h00, 1, -1,     1, -1, "R2");
        expect_ex(16'h02, 1, -1,     1, -1, "R2");
        expect_ex(16'h04, 1, -1,     1, -1, "R2");
        expect_ex(16'h06, 1, -1,     1, -1, "R2");
        expect_ex(16'h08, 5, 'hF111, 1, -1, "R8");
        expect_ex(16'h40, 1, -1,     3, -1, "R8");
        expect_ex(16'h42, 4, -1,     1, -1, "R8");
        expect_ex(16'h0C, 1, -1,     2,  0, "R8");
        expect_ex(16'h0E, 1, -1,     1, -1, "R2");
        irq_mode = 1;
        leave_reset("R1");
        drain(60, "R8");
        chk(irq_done == 1'b1, "R8", "interrupt was acknowledged", int'(irq_done), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule